// File: doc/BRIEF.md
# Sync-Word-Gated Receive Bit FIFO

This block sits behind a demodulator on the receive side of a serial radio path. Each cycle it may take one data bit, marked by a valid strobe. It keeps a bit-wide FIFO that a host drains through a simple read port. A command decoder delivers 16-bit configuration words, and the block accepts only those whose upper byte carries its own command code. The low byte of an accepted word sets four things: an interrupt threshold, how filling starts, a fill enable, and a stored flag that turns off the supply-glitch reset.

While filling is enabled, the block runs in one of two modes. In the free-running mode it stores every received bit. In the gated mode it first watches the stream for a hard-wired 16-bit synchronisation word, and only the bits after that word go into the FIFO. Dropping the fill enable flushes the FIFO, clears the interrupt and re-arms the search.

The interrupt tells the host that enough bits are waiting. A sticky overrun flag records any bit that arrived while the FIFO was full.

Top module: `rx_bit_fifo`

## Requirements
- R1: A configuration word takes effect only when `cfg_word[15:8]` equals CAh. A word with any other upper byte changes no setting and no output.
- R2: After reset the settings are: threshold 8, start mode 0, fill enable 0, glitch-disable 0. The outputs `level`, `irq`, `ovr` and `fill_active` are all 0.
- R3: When fill enable (bit 1) is 1 and start mode (bit 2) is 1, every bit with `rx_valid` high is stored, and `level` counts the stored bits.
- R4: When start mode is 0, the detector shifts each valid bit into a 16-bit window, with the first bit received ending up as the most significant bit. Storing begins with the first bit after the valid bit that completes the window value 2DD4h; that completing bit is not stored. Once locked, storing continues until a flush. The detector only runs while fill enable is 1.
- R5: An accepted word with bit 1 at 0 empties the FIFO on the next clock edge, drops `irq` and `fill_active`, and clears the detector. Sync search resumes only after bit 1 is set again.
- R6: `irq` is high exactly when `level` is at least the threshold held in bits [7:4]. A threshold of 0 counts as 1.
- R7: A `rd_req` pops 8 bits when `level` is 8 or more. In that case `rd_data[7]` holds the oldest bit and `rd_data[0]` the eighth oldest. Otherwise a `rd_req` pops one bit, shown in `rd_data[0]` with bits [7:1] at 0. With an empty FIFO, `rd_data` is 0 and `rd_req` has no effect.
- R8: A bit that would be stored while the FIFO is still full after any same-cycle pop is discarded, and `ovr` is set. `stat_rd` clears `ovr`. If a new discard happens in the same cycle, setting wins.
- R9: Bit 0 of an accepted word drives `glitch_rst_dis`. Bit 3 is ignored.
- R10: The FIFO holds at most 16 bits, so `level` never exceeds 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration word strobe |
| cfg_word | input | 16 | Command code and settings |
| rx_valid | input | 1 | Received bit strobe |
| rx_bit | input | 1 | Received data bit |
| rd_req | input | 1 | Pop request |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_data | output | 8 | Head byte or head bit of the FIFO |
| level | output | 5 | Number of stored bits |
| irq | output | 1 | Threshold reached |
| ovr | output | 1 | Sticky overrun flag |
| fill_active | output | 1 | Bits are currently being stored |
| glitch_rst_dis | output | 1 | Stored glitch-reset disable bit |

## Verification
The free-running mode is driven with short mixed patterns and with a burst that overfills the FIFO. The short patterns separate correct ordering and threshold behaviour from off-by-one counting, and the burst shows whether excess bits are dropped and flagged. The gated mode is fed noise that contains near misses of the sync word, then the sync word itself, then a known byte. This exposes a detector that locks early, one that stores the sync word's last bit, and one that reads the byte in the wrong bit order. Toggling the enable off and on, followed by plain data, shows whether the search was truly re-armed or the lock survived the flush.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam logic [7:0]  CMD_CODE  = 8'hCA;
  localparam logic [15:0] SYNC_WORD = 16'h2DD4;
  localparam logic [3:0]  THR_RESET = 4'd8;

  typedef struct packed {
    logic [3:0] thr;
    logic       start_free;
    logic       fill_en;
    logic       glitch_dis;
  } cfg_t;

  // Threshold of zero behaves as one stored bit
  function automatic logic [4:0] irq_floor(input logic [3:0] thr);
    return (thr == 4'd0) ? 5'd1 : {1'b0, thr};
  endfunction
endpackage

// File: rtl/rxf_cfg.sv
module rxf_cfg
  import rxf_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [15:0] cfg_word,
  output cfg_t        cfg,
  output logic        cmd_hit,
  output logic        flush
);
  assign cmd_hit = cfg_valid && (cfg_word[15:8] == CMD_CODE);
  assign flush   = cmd_hit && !cfg_word[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg.thr        <= THR_RESET;
      cfg.start_free <= 1'b0;
      cfg.fill_en    <= 1'b0;
      cfg.glitch_dis <= 1'b0;
    end else if (cmd_hit) begin
      cfg.thr        <= cfg_word[7:4];
      cfg.start_free <= cfg_word[2];
      cfg.fill_en    <= cfg_word[1];
      cfg.glitch_dis <= cfg_word[0];
    end
  end
endmodule

// File: rtl/rxf_sync.sv
module rxf_sync #(
  parameter int          W       = 16,
  parameter logic [15:0] PATTERN = 16'h2DD4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic flush,
  input  logic bit_valid,
  input  logic bit_in,
  output logic hit,
  output logic locked
);
  logic [W-1:0] sr;
  logic [W-1:0] window;

  assign window = {sr[W-2:0], bit_in};
  assign hit    = en && bit_valid && (window == PATTERN[W-1:0]);

  always_ff @(posedge clk) begin
    if (!rst_n || flush || !en) begin
      sr     <= '0;
      locked <= 1'b0;
    end else if (bit_valid) begin
      sr <= window;
      if (hit) locked <= 1'b1;
    end
  end
endmodule

// File: rtl/rxf_bitq.sv
module rxf_bitq #(
  parameter int DEPTH = 16,
  parameter int RD_W  = 8,
  localparam int LW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            push,
  input  logic            bit_in,
  input  logic            pop,
  input  logic            stat_clr,
  output logic [LW-1:0]   level,
  output logic [RD_W-1:0] rd_data,
  output logic            ovr,
  output logic            drop
);
  logic [DEPTH-1:0] q, q_next;
  logic [LW-1:0]    pop_n, lvl_after;
  logic             take;
  logic [IW-1:0]    idx;

  always_comb begin
    if (!pop || level == '0) pop_n = '0;
    else if (level >= LW'(RD_W)) pop_n = LW'(RD_W);
    else pop_n = LW'(1);
  end

  assign lvl_after = level - pop_n;
  assign take      = push && (lvl_after < LW'(DEPTH));
  assign drop      = push && !take;
  assign idx       = lvl_after[IW-1:0];

  always_comb begin
    q_next = q >> pop_n;
    if (take) q_next[idx] = bit_in;
  end

  always_comb begin
    rd_data = '0;
    if (level >= LW'(RD_W)) begin
      for (int i = 0; i < RD_W; i++) rd_data[RD_W-1-i] = q[i];
    end else if (level != '0) begin
      rd_data[0] = q[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      q     <= '0;
      level <= '0;
    end else begin
      q     <= q_next;
      level <= lvl_after + LW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovr <= 1'b0;
    else if (drop) ovr <= 1'b1;
    else if (stat_clr) ovr <= 1'b0;
  end
endmodule

// File: rtl/rx_bit_fifo.sv
module rx_bit_fifo
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int RD_W  = 8,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_valid,
  input  logic [15:0]     cfg_word,
  input  logic            rx_valid,
  input  logic            rx_bit,
  input  logic            rd_req,
  input  logic            stat_rd,
  output logic [RD_W-1:0] rd_data,
  output logic [LW-1:0]   level,
  output logic            irq,
  output logic            ovr,
  output logic            fill_active,
  output logic            glitch_rst_dis
);
  cfg_t cfg;
  logic cmd_hit, flush, sync_hit, locked, push, drop;

  rxf_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .cfg(cfg), .cmd_hit(cmd_hit), .flush(flush)
  );

  rxf_sync #(.W(16), .PATTERN(SYNC_WORD)) u_sync (
    .clk(clk), .rst_n(rst_n), .en(cfg.fill_en), .flush(flush),
    .bit_valid(rx_valid), .bit_in(rx_bit), .hit(sync_hit), .locked(locked)
  );

  assign fill_active = cfg.fill_en && (cfg.start_free || locked);
  assign push        = rx_valid && fill_active;

  rxf_bitq #(.DEPTH(DEPTH), .RD_W(RD_W)) u_q (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push(push), .bit_in(rx_bit),
    .pop(rd_req), .stat_clr(stat_rd), .level(level), .rd_data(rd_data),
    .ovr(ovr), .drop(drop)
  );

  assign irq            = level >= LW'(irq_floor(cfg.thr));
  assign glitch_rst_dis = cfg.glitch_dis;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 16,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_valid,
  input logic [15:0]   cfg_word,
  input logic [LW-1:0] level,
  input logic          irq,
  input logic          ovr,
  input logic          fill_active,
  input logic          glitch_rst_dis,
  input logic          flush,
  input logic          drop,
  input logic          sync_hit
);
  assert_level_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  assert_full_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !flush) |=> level == LW'(DEPTH));

  assert_foreign_cmd_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_word[15:8] != 8'hCA) |=> $stable(glitch_rst_dis));

  assert_flush_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_word[15:8] == 8'hCA && !cfg_word[1]) |=>
      (level == '0 && !irq && !fill_active));

  assert_sync_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_hit && !flush) |=> fill_active);

  assert_irq_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> level != '0);

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ovr);

  assert_glitch_bit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_valid && cfg_word[15:8] == 8'hCA) |=> glitch_rst_dis == $past(cfg_word[0]));
endmodule

bind rx_bit_fifo rxf_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
  .level(level), .irq(irq), .ovr(ovr), .fill_active(fill_active),
  .glitch_rst_dis(glitch_rst_dis), .flush(flush), .drop(drop),
  .sync_hit(sync_hit)
);

// File: tb/sim_rx_bit_fifo.sv
`timescale 1ns/100ps
module sim_rx_bit_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic [15:0] cfg_word = '0;
  logic        rx_valid = 1'b0, rx_bit = 1'b0, rd_req = 1'b0, stat_rd = 1'b0;
  logic [7:0]  rd_data;
  logic [4:0]  level;
  logic        irq, ovr, fill_active, glitch_rst_dis;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rx_bit_fifo u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .rx_valid(rx_valid), .rx_bit(rx_bit), .rd_req(rd_req), .stat_rd(stat_rd),
    .rd_data(rd_data), .level(level), .irq(irq), .ovr(ovr),
    .fill_active(fill_active), .glitch_rst_dis(glitch_rst_dis)
  );

  // Behavioural reference
  bit        mq[$];
  int        m_thr = 8;
  bit        m_free, m_en, m_dis, m_lock, m_ovr;
  bit [15:0] m_sr;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_rd();
    int v = 0;
    if (mq.size() >= 8) begin
      for (int i = 0; i < 8; i++) v = (v << 1) | int'(mq[i]);
    end else if (mq.size() > 0) v = int'(mq[0]);
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq.delete(); m_thr = 8; m_free = 0; m_en = 0; m_dis = 0;
      m_lock = 0; m_ovr = 0; m_sr = '0;
    end else begin
      bit storing, dropped, acc;
      acc = cfg_valid && cfg_word[15:8] == 8'hCA;
      storing = m_en && (m_free || m_lock);
      dropped = 0;
      if (rd_req) begin
        if (mq.size() >= 8) repeat (8) void'(mq.pop_front());
        else if (mq.size() > 0) void'(mq.pop_front());
      end
      if (rx_valid && m_en) begin
        if (storing) begin
          if (mq.size() < 16) mq.push_back(rx_bit);
          else dropped = 1;
        end
        m_sr = {m_sr[14:0], rx_bit};
        if (m_sr == 16'h2DD4) m_lock = 1;
      end
      if (stat_rd) m_ovr = 0;
      if (dropped) m_ovr = 1;
      if (acc) begin
        m_thr = int'(cfg_word[7:4]); m_free = cfg_word[2];
        m_en = cfg_word[1]; m_dis = cfg_word[0];
        if (!cfg_word[1]) begin mq.delete(); m_sr = '0; m_lock = 0; end
      end
      #1;
      check(int'(level) == mq.size(), "R3 level", int'(level), mq.size());
      check(irq == (mq.size() >= ((m_thr == 0) ? 1 : m_thr)), "R6 irq", int'(irq), int'(!irq));
      check(ovr == m_ovr, "R8 ovr", int'(ovr), int'(m_ovr));
      check(int'(rd_data) == exp_rd(), "R7 rd_data", int'(rd_data), exp_rd());
      check(glitch_rst_dis == m_dis, "R9 glitch", int'(glitch_rst_dis), int'(m_dis));
      check(fill_active == (m_en && (m_free || m_lock)), "R4 fill_active",
            int'(fill_active), int'(m_en && (m_free || m_lock)));
    end
  end

  // Stimulus tasks: called at a negedge, return at the next negedge
  task automatic wr_cfg(input logic [15:0] w);
    cfg_valid = 1; cfg_word = w; @(negedge clk); cfg_valid = 0;
  endtask
  task automatic send_bit(input logic b, input logic rd = 0);
    rx_valid = 1; rx_bit = b; rd_req = rd; @(negedge clk); rx_valid = 0; rd_req = 0;
  endtask
  task automatic send16(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask
  task automatic pop_one();
    rd_req = 1; @(negedge clk); rd_req = 0;
  endtask
  task automatic read_status();
    stat_rd = 1; @(negedge clk); stat_rd = 0;
  endtask

  initial begin
    #(200000 * 5);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(level == 0 && !irq && !ovr && !fill_active && !glitch_rst_dis,
          "R2 reset", {level, irq, ovr, fill_active, glitch_rst_dis}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1: foreign command code ignored
    wr_cfg(16'hCB0F);
    send_bit(1); send_bit(0);
    check(!fill_active && !glitch_rst_dis && level == 0, "R1 foreign code",
          {fill_active, glitch_rst_dis, level}, 0);

    // R3/R9: free-running, thr 4, bit3 set (ignored), glitch disable set
    wr_cfg(16'hCA4F);
    check(glitch_rst_dis == 1, "R9 glitch out", int'(glitch_rst_dis), 1);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0); send_bit(1);
    check(level == 6 && irq, "R3 free fill", int'(level), 6);
    pop_one(); pop_one(); pop_one();
    check(level == 3 && !irq, "R6 irq drop below thr", int'(level), 3);

    // R8/R10: overfill
    for (int i = 0; i < 17; i++) send_bit(i[0]);
    check(level == 16 && ovr, "R10 full with overrun", int'(level), 16);
    send_bit(1, 1);
    check(level == 9, "R8 push after pop", int'(level), 9);
    pop_one();
    pop_one();
    read_status();
    check(!ovr, "R8 status clears", int'(ovr), 0);
    pop_pop_empty();

    // R5: flush
    for (int i = 0; i < 5; i++) send_bit(1);
    wr_cfg(16'hCA40);
    check(level == 0 && !irq && !fill_active, "R5 flush", int'(level), 0);

    // R4: gated by sync word, thr 8
    wr_cfg(16'hCA82);
    send16(16'h1234); send16(16'h2DD5); send16(16'hADD4);
    check(level == 0 && !fill_active, "R4 no early lock", int'(level), 0);
    send16(16'h2DD4);
    check(fill_active && level == 0, "R4 sync bit not stored", int'(level), 0);
    send16(16'hA53C);
    check(level == 16 && irq && rd_data == 8'hA5, "R7 byte order", int'(rd_data), 8'hA5);
    pop_one();
    check(rd_data == 8'h3C, "R7 second byte", int'(rd_data), 8'h3C);

    // R5: re-arm after flush
    wr_cfg(16'hCA80);
    wr_cfg(16'hCA82);
    send16(16'hFFFF);
    check(level == 0 && !fill_active, "R5 search re-armed", int'(level), 0);

    // R6: threshold zero acts as one
    wr_cfg(16'hCA06);
    check(!irq, "R6 thr0 empty", int'(irq), 0);
    send_bit(0);
    check(irq && rd_data == 0 && level == 1, "R6 thr0 one bit", int'(irq), 1);
    pop_one();
    pop_one();
    check(level == 0, "R7 empty read", int'(level), 0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic pop_pop_empty();
    for (int i = 0; i < 10; i++) pop_one();
    check(level == 0 && rd_data == 0, "R7 drain to empty", int'(level), 0);
  endtask
endmodule